// File: doc/BRIEF.md
# Prescaled seconds counter with alarm

The block is a memory-mapped timer. A free-running up-counter runs from a slow clock, and a programmable prescaler sits in front of it. If the prescaler is loaded with the slow-clock frequency, the counter advances once per second.

Software uses four 32-bit registers on a simple synchronous register bus in the fast bus-clock domain:

- **Mode** (0x00) holds the prescaler, two interrupt enables and a restart strobe.
- **Alarm** (0x04) holds a 32-bit compare value.
- **Value** (0x08) is the current count. It is read-only.
- **Status** (0x0C) holds two event flags. Reading it clears them.

The counter cannot be loaded; it can only be restarted from zero. One interrupt line combines each status flag with its enable.

The counter and its divider live in the slow domain. Configuration crosses into that domain through two-flop synchronisers. The count comes back in Gray code, so a read near an increment yields either the old or the new value, never a mix. Increment and alarm events come back as toggles.

Restarts use a toggle handshake run by a small bus-side state machine:

- **RS_IDLE**: no restart is in flight. A write with the restart bit flips the request and moves to RS_PEND.
- **RS_PEND**: the request is waiting for the slow-domain acknowledge.
  - Acknowledge returns: go back to RS_IDLE.
  - Another restart write arrives: go to RS_PEND_AGAIN.
  - Acknowledge and a new restart write arrive together: flip the request again and stay in RS_PEND.
- **RS_PEND_AGAIN**: a second restart is queued. When the acknowledge returns, the request is flipped again and the machine goes back to RS_PEND.

Top module: `seconds_timer`

## Requirements
- R1: After reset:
  - mode reads 0x0000_0000
  - alarm reads 0xFFFF_FFFF
  - value reads 0
  - status reads 0
  - irq is low.
- R2: Register decoding uses byte offset bits [3:2]: 0x00 mode, 0x04 alarm, 0x08 value, 0x0C status. The alarm is a full 32-bit read/write register.
- R3: Mode bits [15:0] hold a prescaler P. After a restart, the counter increases by exactly 1 every P slow-clock cycles. P = 0 acts as 65536 cycles per increment.
- R4: Writing 1 to mode bit 18 restarts the timer: the counter and the divider go to zero. Bit 18 always reads back 0, and the prescaler and enable bits keep the values written with it.
- R5: The value register cannot be written. A bus write to value or to status leaves both unchanged.
- R6: Status bit 1 sets on each counter increment. Status bit 0 sets when an increment makes the counter equal to the alarm value. A restart does not count as an increment.
- R7: A status read returns the flags and then clears them. A flag whose event lands in the same bus cycle as the read stays set for the next read.
- R8: irq = (status[0] AND mode[16]) OR (status[1] AND mode[17]).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sclk | input | 1 | Slow counting clock |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can fall in the same bus cycle are a status read and the arrival of an increment event. The bench provokes this by issuing a status read on every bus cycle for a window of about twenty increments, with a two-cycle prescaler, so every arrival coincides with a read. It judges the result by comparing the number of reads that saw the increment flag with the advance of the value register over the window. The two must agree to within one, since the two paths have slightly different latency; a design that lets the clear win would show almost no flags.

// File: rtl/sectmr_pkg.sv
package sectmr_pkg;
    localparam int unsigned WORD_MODE   = 0;
    localparam int unsigned WORD_ALARM  = 1;
    localparam int unsigned WORD_VALUE  = 2;
    localparam int unsigned WORD_STATUS = 3;

    localparam int unsigned BIT_ALM_EN  = 16;
    localparam int unsigned BIT_INC_EN  = 17;
    localparam int unsigned BIT_RESTART = 18;

    localparam int unsigned BUS_W = 32;

    typedef enum logic [1:0] {
        RS_IDLE       = 2'd0,
        RS_PEND       = 2'd1,
        RS_PEND_AGAIN = 2'd2
    } restart_state_t;
endpackage

// File: rtl/sectmr_sync.sv
module sectmr_sync #(
    parameter int unsigned W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/sectmr_tick.sv
module sectmr_tick #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned PRE_W = 16
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] presc_s,
    input  logic [CNT_W-1:0] alarm_s,
    input  logic             req_s,
    output logic             ack_tgl,
    output logic             inc_tgl,
    output logic             alm_tgl,
    output logic [CNT_W-1:0] cnt_gray
);
    logic [PRE_W-1:0] div;
    logic [CNT_W-1:0] cnt;
    logic             req_seen;
    logic             restart_apply;
    logic             tick;
    logic [PRE_W-1:0] lim;
    logic [CNT_W-1:0] cnt_inc;

    assign restart_apply = (req_s != req_seen);
    assign lim           = presc_s - PRE_W'(1);
    assign tick          = (div >= lim);
    assign cnt_inc       = cnt + CNT_W'(1);
    assign ack_tgl       = req_seen;

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            div      <= '0;
            cnt      <= '0;
            cnt_gray <= '0;
            req_seen <= 1'b0;
            inc_tgl  <= 1'b0;
            alm_tgl  <= 1'b0;
        end else if (restart_apply) begin
            req_seen <= req_s;
            div      <= '0;
            cnt      <= '0;
            cnt_gray <= '0;
        end else if (tick) begin
            div      <= '0;
            cnt      <= cnt_inc;
            cnt_gray <= cnt_inc ^ (cnt_inc >> 1);
            inc_tgl  <= ~inc_tgl;
            if (cnt_inc == alarm_s) begin
                alm_tgl <= ~alm_tgl;
            end
        end else begin
            div <= div + PRE_W'(1);
        end
    end

    AST_CNT_STEP: assert property (@(posedge sclk) disable iff (!rst_n)
        !restart_apply |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1))); // R3

    AST_RESTART_CLEARS: assert property (@(posedge sclk) disable iff (!rst_n)
        restart_apply |=> (cnt == '0 && div == '0)); // R4

    AST_INC_FLIP: assert property (@(posedge sclk) disable iff (!rst_n)
        (!restart_apply && tick) |=> (inc_tgl != $past(inc_tgl))); // R6
endmodule

// File: rtl/sectmr_regs.sv
module sectmr_regs
    import sectmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned PRE_W  = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq,
    input  logic [CNT_W-1:0]  cnt_gray_b,
    input  logic              inc_b,
    input  logic              alm_b,
    input  logic              ack_b,
    output logic [PRE_W-1:0]  presc_q,
    output logic [CNT_W-1:0]  alarm_q,
    output logic              req_q
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              wr_mode;
    logic              wr_alarm;
    logic              rd_status;
    logic              restart_wr;
    logic              alm_en_q;
    logic              inc_en_q;
    logic              inc_prev;
    logic              alm_prev;
    logic [1:0]        set_v;
    logic [1:0]        status_q;
    logic [1:0]        status_d;
    logic [CNT_W-1:0]  cnt_bin;
    logic              addr_unused;
    restart_state_t    state_q;
    restart_state_t    state_d;
    logic              flip;
    logic              ack_match;

    assign word        = bus_addr[ADDR_W-1:2];
    assign addr_unused = ^{bus_addr[1:0], bus_wdata[BUS_W-1:BIT_RESTART+1]};
    assign wr_mode     = bus_sel && bus_wr && (word == WORD_W'(WORD_MODE));
    assign wr_alarm    = bus_sel && bus_wr && (word == WORD_W'(WORD_ALARM));
    assign rd_status   = bus_sel && !bus_wr && (word == WORD_W'(WORD_STATUS));
    assign restart_wr  = wr_mode && bus_wdata[BIT_RESTART];
    assign ack_match   = (ack_b == req_q);

    // event edges: bit 1 = increment, bit 0 = alarm match
    assign set_v    = {inc_b ^ inc_prev, alm_b ^ alm_prev};
    assign status_d = (rd_status ? 2'b00 : status_q) | set_v;

    always_comb begin
        cnt_bin[CNT_W-1] = cnt_gray_b[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            cnt_bin[i] = cnt_bin[i+1] ^ cnt_gray_b[i];
        end
    end

    // restart handshake state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            req_q   <= req_q ^ flip;
        end
    end

    // restart handshake next state and request flip
    always_comb begin
        state_d = state_q;
        flip    = 1'b0;
        unique case (state_q)
            RS_IDLE: begin
                if (restart_wr) begin
                    flip    = 1'b1;
                    state_d = RS_PEND;
                end
            end
            RS_PEND: begin
                if (ack_match && restart_wr) begin
                    flip = 1'b1;
                end else if (ack_match) begin
                    state_d = RS_IDLE;
                end else if (restart_wr) begin
                    state_d = RS_PEND_AGAIN;
                end
            end
            RS_PEND_AGAIN: begin
                if (ack_match) begin
                    flip    = 1'b1;
                    state_d = RS_PEND;
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q  <= '0;
            alm_en_q <= 1'b0;
            inc_en_q <= 1'b0;
            alarm_q  <= '1;
            inc_prev <= 1'b0;
            alm_prev <= 1'b0;
            status_q <= 2'b00;
        end else begin
            inc_prev <= inc_b;
            alm_prev <= alm_b;
            status_q <= status_d;
            if (wr_mode) begin
                presc_q  <= bus_wdata[PRE_W-1:0];
                alm_en_q <= bus_wdata[BIT_ALM_EN];
                inc_en_q <= bus_wdata[BIT_INC_EN];
            end
            if (wr_alarm) begin
                alarm_q <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (word)
            WORD_W'(WORD_MODE): begin
                bus_rdata[PRE_W-1:0]  = presc_q;
                bus_rdata[BIT_ALM_EN] = alm_en_q;
                bus_rdata[BIT_INC_EN] = inc_en_q;
            end
            WORD_W'(WORD_ALARM):  bus_rdata[CNT_W-1:0] = alarm_q;
            WORD_W'(WORD_VALUE):  bus_rdata[CNT_W-1:0] = cnt_bin;
            WORD_W'(WORD_STATUS): bus_rdata[1:0] = status_q;
            default:              bus_rdata = '0;
        endcase
    end

    assign irq = |(status_q & {inc_en_q, alm_en_q});

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != 2'b00) |=> ((status_q & $past(set_v)) == $past(set_v))); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && set_v == 2'b00) |=> (status_q == 2'b00)); // R7

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_en_q && !inc_en_q) |-> !irq); // R8

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_PEND && !ack_match) |=> (state_q != RS_IDLE)); // R4
endmodule

// File: rtl/seconds_timer.sv
module seconds_timer
    import sectmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned PRE_W  = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    logic [PRE_W-1:0] presc_q, presc_s;
    logic [CNT_W-1:0] alarm_q, alarm_s;
    logic [CNT_W-1:0] cnt_gray, cnt_gray_b;
    logic             req_q, req_s;
    logic             ack_tgl, inc_tgl, alm_tgl;
    logic             ack_b, inc_b, alm_b;

    sectmr_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq        (irq),
        .cnt_gray_b (cnt_gray_b),
        .inc_b      (inc_b),
        .alm_b      (alm_b),
        .ack_b      (ack_b),
        .presc_q    (presc_q),
        .alarm_q    (alarm_q),
        .req_q      (req_q)
    );

    // bus -> slow domain
    sectmr_sync #(.W(PRE_W), .RST_VAL('0)) u_sync_presc (
        .clk(sclk), .rst_n(rst_n), .d(presc_q), .q(presc_s));
    sectmr_sync #(.W(CNT_W), .RST_VAL('1)) u_sync_alarm (
        .clk(sclk), .rst_n(rst_n), .d(alarm_q), .q(alarm_s));
    sectmr_sync #(.W(1), .RST_VAL(1'b0)) u_sync_req (
        .clk(sclk), .rst_n(rst_n), .d(req_q), .q(req_s));

    sectmr_tick #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tick (
        .sclk     (sclk),
        .rst_n    (rst_n),
        .presc_s  (presc_s),
        .alarm_s  (alarm_s),
        .req_s    (req_s),
        .ack_tgl  (ack_tgl),
        .inc_tgl  (inc_tgl),
        .alm_tgl  (alm_tgl),
        .cnt_gray (cnt_gray)
    );

    // slow -> bus domain
    sectmr_sync #(.W(CNT_W), .RST_VAL('0)) u_sync_cnt (
        .clk(clk), .rst_n(rst_n), .d(cnt_gray), .q(cnt_gray_b));
    sectmr_sync #(.W(3), .RST_VAL(3'b000)) u_sync_evt (
        .clk(clk), .rst_n(rst_n),
        .d({ack_tgl, inc_tgl, alm_tgl}), .q({ack_b, inc_b, alm_b}));
endmodule

// File: tb/seconds_timer_tb.sv
module seconds_timer_tb;
    logic        clk = 1'b0;
    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    localparam logic [3:0] A_MODE = 4'h0, A_ALARM = 4'h4, A_VALUE = 4'h8, A_STATUS = 4'hC;
    localparam logic [31:0] EN_ALM = 32'h1 << 16, EN_INC = 32'h1 << 17, RESTART = 32'h1 << 18;

    always #4 clk = ~clk;     // 125 MHz bus clock
    always #28 sclk = ~sclk;  // slow clock, 7x the bus period

    seconds_timer u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input string what, input longint got, input longint exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic slow_wait(input int n);
        repeat (n) @(posedge sclk);
        @(negedge clk);
    endtask

    task automatic irq_sample(output logic v);
        @(negedge clk);
        #1 v = irq;
    endtask

    localparam int P = 16;

    initial begin
        logic [31:0] rd;
        logic [31:0] v0;
        logic [31:0] v1;
        logic        iv;
        int          hits;
        int          delta;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1 reset values
        irq_sample(iv);            check("R1", "irq after reset", iv, 0);
        bus_read(A_MODE, rd);      check("R1", "mode after reset", rd, 0);
        bus_read(A_ALARM, rd);     check("R1", "alarm after reset", rd, 32'hFFFF_FFFF);
        bus_read(A_VALUE, rd);     check("R1", "value after reset", rd, 0);
        bus_read(A_STATUS, rd);    check("R1", "status after reset", rd, 0);

        // R3/R4: prescaler P with restart, bit 18 reads 0
        bus_write(A_MODE, P | RESTART);
        bus_read(A_MODE, rd);      check("R4", "mode readback after restart", rd, P);
        slow_wait(3 * P + P / 2);
        bus_read(A_VALUE, rd);     check("R3", "value after 3.5 periods", rd, 3);

        // R5: writes to value and status ignored
        bus_write(A_VALUE, 32'h0000_1234);
        bus_read(A_VALUE, rd);     check("R5", "value after write attempt", rd, 3);

        // R6/R7: increment flag, cleared by read; R8 masked irq
        irq_sample(iv);            check("R8", "irq with no enables", iv, 0);
        bus_read(A_STATUS, rd);    check("R6", "status after increments", rd, 2);
        bus_read(A_STATUS, rd);    check("R7", "status after clearing read", rd, 0);
        bus_write(A_STATUS, 32'h3);
        bus_read(A_STATUS, rd);    check("R5", "status after write attempt", rd, 0);

        // R8: increment interrupt
        bus_write(A_MODE, P | EN_INC);
        irq_sample(iv);            check("R8", "inc irq before event", iv, 0);
        slow_wait(P);
        irq_sample(iv);            check("R8", "inc irq after increment", iv, 1);
        bus_read(A_STATUS, rd);    check("R7", "status with inc flag", rd, 2);
        irq_sample(iv);            check("R8", "inc irq after status read", iv, 0);

        // R6/R8: alarm match at count 2, only alarm irq enabled
        bus_write(A_ALARM, 32'd2);
        bus_read(A_ALARM, rd);     check("R2", "alarm readback", rd, 2);
        bus_write(A_MODE, P | EN_ALM | RESTART);
        bus_read(A_STATUS, rd);
        bus_read(A_MODE, rd);      check("R4", "enables kept across restart", rd, P | EN_ALM);
        slow_wait(P + P / 2 - 1);
        irq_sample(iv);            check("R8", "inc flag masked by alarm-only enable", iv, 0);
        slow_wait(P);
        irq_sample(iv);            check("R8", "alarm irq after match", iv, 1);
        bus_read(A_STATUS, rd);    check("R6", "status with alarm and inc", rd, 3);
        irq_sample(iv);            check("R8", "alarm irq after status read", iv, 0);
        slow_wait(P);
        bus_read(A_STATUS, rd);    check("R6", "no second alarm flag", rd, 2);
        bus_read(A_VALUE, rd);     check("R3", "value after alarm test", rd, 3);

        // R7: status read on every cycle across many increments
        bus_write(A_MODE, 2 | EN_INC);
        slow_wait(4);
        bus_read(A_VALUE, v0);
        hits = 0;
        for (int i = 0; i < 280; i++) begin
            bus_read(A_STATUS, rd);
            if (rd[1]) hits++;
        end
        bus_read(A_VALUE, v1);
        delta = int'(v1 - v0);
        check("R7", "increment count seen by reads is plausible", (delta >= 10) ? 1 : 0, 1);
        check("R7", "flags seen vs value advance within 1",
              ((hits - delta) <= 1 && (delta - hits) <= 1) ? 1 : 0, 1);

        // R3: prescaler 0 means 65536 cycles
        bus_write(A_MODE, RESTART);
        bus_read(A_MODE, rd);      check("R4", "mode readback with prescaler 0", rd, 0);
        slow_wait(10);
        bus_read(A_STATUS, rd);
        slow_wait(600);
        bus_read(A_VALUE, rd);     check("R3", "no increment with prescaler 0", rd, 0);
        bus_read(A_STATUS, rd);    check("R3", "no inc flag with prescaler 0", rd, 0);

        // R2: full-width alarm
        bus_write(A_ALARM, 32'hA5A5_0F0F);
        bus_read(A_ALARM, rd);     check("R2", "alarm full-width readback", rd, 32'hA5A5_0F0F);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule